// File: doc/BRIEF.md
# Wait/Stop Low-Power Clock Controller

This block decides when the processor core and the peripherals receive clock enables. A one-cycle wait strobe or stop strobe from the instruction decoder moves it out of the run state. In the wait state the core clock enable drops and the peripheral clock enable stays high. In the stop state both enables drop. Entering either state emits a one-cycle pulse that clears the interrupt mask bit of the condition code register, so that an interrupt can bring the core back.

In the wait state, any peripheral interrupt request whose matching enable bit is set wakes the core. The external interrupt also wakes it. In the stop state only the external interrupt wakes it. On wake, the core clock enable comes back in the same cycle as a one-cycle stacking-start pulse, and the mode returns to run. Several reset sources come in as a vector. They all have equal and top priority, and any one of them puts the controller back in the run state. All outputs are registered.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: In the run state, a wait or stop strobe produces `imask_clr` = 1 in the cycle after the strobe is sampled, lasting exactly one cycle.
- R2: In the wait state, `mode` = 1, `cpu_clk_en` = 0 and `per_clk_en` = 1.
- R3: In the stop state, `mode` = 2 and both `cpu_clk_en` and `per_clk_en` are 0.
- R4: In the wait state, a request on `irq_req[i]` with `irq_en[i]` = 1, or `ext_irq` = 1, wakes the controller. A request whose enable bit is 0 leaves it in the wait state.
- R5: A wake sampled at a clock edge gives `stack_start` = 1, `cpu_clk_en` = 1, `per_clk_en` = 1 and `mode` = 0 right after that edge. `stack_start` lasts one cycle.
- R6: In the stop state, peripheral requests are ignored even when enabled. Only `ext_irq` wakes the controller.
- R7: Any single bit of `rst_src` set at an edge gives `mode` = 0, both clock enables 1 and both pulses 0 after that edge, whatever the other inputs are.
- R8: Wait and stop strobes sampled together in the run state enter the stop state.
- R9: Strobes sampled in the wait or stop state change nothing: the mode is kept and no `imask_clr` pulse is produced.
- R10: In the run state with no strobe, `mode` = 0, both clock enables are 1 and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_src | input | NUM_RST | Reset sources, active high, equal priority |
| wait_stb | input | 1 | Wait instruction strobe |
| stop_stb | input | 1 | Stop instruction strobe |
| irq_req | input | NUM_IRQ | Peripheral interrupt requests |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| ext_irq | input | 1 | External interrupt request |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask_clr | output | 1 | Pulse clearing the interrupt mask bit |
| stack_start | output | 1 | Pulse starting interrupt stacking |
| mode | output | 2 | 0 run, 1 wait, 2 stop |

## Verification
The bench builds the block with NUM_IRQ = 6 and NUM_RST = 3. Six interrupt lines let every line be tried on its own, once with its enable set and once with it clear. Three reset sources let each source be shown, on its own, to force the run state from the stop state. The random phase draws independent request and enable patterns over the whole line vector. It also draws strobe collisions and reset pulses at chosen rates, so every transition of the mode machine, including wake and strobe in the same cycle, is reached many times.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2
  } lpm_mode_e;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               per_wake
);
  logic [NUM_IRQ-1:0] line_hit;

  // Each line can wake the core only when its own enable is set.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign line_hit[i] = irq_req[i] & irq_en[i];
  end

  assign per_wake = |line_hit;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wait_stb,
  input  logic      stop_stb,
  input  logic      per_wake,
  input  logic      ext_wake,
  output lpm_mode_e mode_q,
  output logic      cpu_en_q,
  output logic      per_en_q,
  output logic      imask_clr_q,
  output logic      stack_q
);
  lpm_mode_e mode_d;
  logic      cpu_en_d, per_en_d, imask_clr_d, stack_d;

  always_comb begin
    mode_d      = mode_q;
    cpu_en_d    = cpu_en_q;
    per_en_d    = per_en_q;
    imask_clr_d = 1'b0;
    stack_d     = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        cpu_en_d = 1'b1;
        per_en_d = 1'b1;
        if (stop_stb) begin
          // stop takes precedence over a simultaneous wait
          mode_d      = MODE_STOP;
          cpu_en_d    = 1'b0;
          per_en_d    = 1'b0;
          imask_clr_d = 1'b1;
        end else if (wait_stb) begin
          mode_d      = MODE_WAIT;
          cpu_en_d    = 1'b0;
          imask_clr_d = 1'b1;
        end
      end
      MODE_WAIT: begin
        if (per_wake || ext_wake) begin
          mode_d   = MODE_RUN;
          cpu_en_d = 1'b1;
          per_en_d = 1'b1;
          stack_d  = 1'b1;
        end
      end
      MODE_STOP: begin
        if (ext_wake) begin
          mode_d   = MODE_RUN;
          cpu_en_d = 1'b1;
          per_en_d = 1'b1;
          stack_d  = 1'b1;
        end
      end
      default: begin
        mode_d   = MODE_RUN;
        cpu_en_d = 1'b1;
        per_en_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_RUN;
      cpu_en_q    <= 1'b1;
      per_en_q    <= 1'b1;
      imask_clr_q <= 1'b0;
      stack_q     <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      cpu_en_q    <= cpu_en_d;
      per_en_q    <= per_en_d;
      imask_clr_q <= imask_clr_d;
      stack_q     <= stack_d;
    end
  end

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  p_entry_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && (wait_stb || stop_stb)) |=> imask_clr_q);

  p_pulse_single_r1: assert property (@(posedge clk) disable iff (rst)
    imask_clr_q |=> !imask_clr_q);

  p_wait_clocks_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WAIT) |-> (!cpu_en_q && per_en_q));

  p_stop_clocks_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP) |-> (!cpu_en_q && !per_en_q));

  p_wake_stack_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WAIT && (per_wake || ext_wake)) |=>
      (stack_q && cpu_en_q && mode_q == MODE_RUN));

  p_reset_run_r7: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> (mode_q == MODE_RUN && cpu_en_q && per_en_q && !stack_q && !imask_clr_q));

  p_both_strobes_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && wait_stb && stop_stb) |=> (mode_q == MODE_STOP));

  p_strobe_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_RUN && !ext_wake && !per_wake) |=> ($stable(mode_q) && !imask_clr_q));

  p_run_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN) |-> (cpu_en_q && per_en_q));
endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int NUM_RST = 2
) (
  input  logic               clk,
  input  logic [NUM_RST-1:0] rst_src,
  input  logic               wait_stb,
  input  logic               stop_stb,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               ext_irq,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               imask_clr,
  output logic               stack_start,
  output logic [1:0]         mode
);
  logic      rst_any;
  logic      per_wake;
  lpm_mode_e mode_s;

  // All reset sources share one priority level: any of them resets.
  assign rst_any = |rst_src;

  lpm_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .per_wake (per_wake)
  );

  lpm_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst_any),
    .wait_stb    (wait_stb),
    .stop_stb    (stop_stb),
    .per_wake    (per_wake),
    .ext_wake    (ext_irq),
    .mode_q      (mode_s),
    .cpu_en_q    (cpu_clk_en),
    .per_en_q    (per_clk_en),
    .imask_clr_q (imask_clr),
    .stack_q     (stack_start)
  );

  assign mode = mode_s;

  p_stop_ignores_periph_r6: assert property (@(posedge clk) disable iff (rst_any)
    (mode == 2'd2 && !ext_irq) |=> (mode == 2'd2 && !stack_start));

  p_masked_no_wake_r4: assert property (@(posedge clk) disable iff (rst_any)
    (mode == 2'd1 && !ext_irq && ((irq_req & irq_en) == '0)) |=> (mode == 2'd1));
endmodule

// File: tb/lpm_clock_ctrl_tb.sv
module lpm_clock_ctrl_tb;
  localparam int NI = 6;
  localparam int NR = 3;

  logic          clk = 1'b0;
  logic [NR-1:0] rst_src = '1;
  logic          wait_stb = 1'b0, stop_stb = 1'b0, ext_irq = 1'b0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic          cpu_clk_en, per_clk_en, imask_clr, stack_start;
  logic [1:0]    mode;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [1:0] m_mode = 2'd0;

  always #2 clk = ~clk;

  lpm_clock_ctrl #(.NUM_IRQ(NI), .NUM_RST(NR)) u_dut (
    .clk(clk), .rst_src(rst_src), .wait_stb(wait_stb), .stop_stb(stop_stb),
    .irq_req(irq_req), .irq_en(irq_en), .ext_irq(ext_irq),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .imask_clr(imask_clr),
    .stack_start(stack_start), .mode(mode)
  );

  // Expected outputs packed as {mode, cpu_en, per_en, imask_clr, stack_start}.
  function automatic logic [5:0] expect_next(input logic [1:0] cur, input logic w, input logic s,
                                             input logic pw, input logic ex, input logic rs);
    if (rs) return {2'd0, 4'b1100};
    case (cur)
      2'd0: if (s) return {2'd2, 4'b0010};
            else if (w) return {2'd1, 4'b0110};
            else return {2'd0, 4'b1100};
      2'd1: if (pw || ex) return {2'd0, 4'b1101};
            else return {2'd1, 4'b0100};
      default: if (ex) return {2'd0, 4'b1101};
               else return {2'd2, 4'b0000};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] cur, input logic w, input logic s,
                                   input logic [NI-1:0] rq, input logic pw, input logic ex,
                                   input logic rs);
    if (rs) return "R7";
    if (cur == 2'd0) begin
      if (w && s) return "R8";
      if (w || s) return "R1";
      return "R10";
    end
    if ((cur == 2'd1 && pw) || ex) return "R5";
    if (w || s) return "R9";
    if (cur == 2'd1) return (rq != '0) ? "R4" : "R2";
    return (rq != '0) ? "R6" : "R3";
  endfunction

  task automatic step(input logic w, input logic s, input logic [NI-1:0] rq,
                      input logic [NI-1:0] en, input logic ex, input logic [NR-1:0] rs);
    logic [5:0] exp_v, act_v;
    logic       pw;
    string      tag;
    @(negedge clk);
    wait_stb = w; stop_stb = s; irq_req = rq; irq_en = en; ext_irq = ex; rst_src = rs;
    pw    = |(rq & en);
    exp_v = expect_next(m_mode, w, s, pw, ex, |rs);
    tag   = tag_of(m_mode, w, s, rq, pw, ex, |rs);
    @(posedge clk);
    #1;
    act_v = {mode, cpu_clk_en, per_clk_en, imask_clr, stack_start};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual mode=%0d cpu=%b per=%b imask=%b stack=%b expected mode=%0d cpu=%b per=%b imask=%b stack=%b",
               tag, act_v[5:4], act_v[3], act_v[2], act_v[1], act_v[0],
               exp_v[5:4], exp_v[3], exp_v[2], exp_v[1], exp_v[0]);
    end
    m_mode = exp_v[5:4];
  endtask

  task automatic idle(); step(1'b0, 1'b0, '0, '0, 1'b0, '0); endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual still running expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_4c11));
    // R7 reset state, with strobes held during reset
    step(1'b1, 1'b1, '1, '1, 1'b1, '1);
    idle();                                   // R10 idle run
    step(1'b1, 1'b0, '0, '0, 1'b0, '0);       // R1 enter wait
    idle();                                   // R2 hold wait
    step(1'b0, 1'b1, '0, '0, 1'b0, '0);       // R9 stop strobe in wait ignored
    // R4: each line with enable clear stays asleep, then wakes with enable set
    for (int i = 0; i < NI; i++) begin
      step(1'b0, 1'b0, NI'(1) << i, ~(NI'(1) << i), 1'b0, '0);
      step(1'b0, 1'b0, NI'(1) << i, NI'(1) << i, 1'b0, '0);   // R5 wake
      idle();
      step(1'b1, 1'b0, '0, '0, 1'b0, '0);
    end
    step(1'b0, 1'b0, '0, '0, 1'b1, '0);       // R4 external wake from wait
    step(1'b1, 1'b1, '0, '0, 1'b0, '0);       // R8 both strobes: stop
    step(1'b0, 1'b0, '1, '1, 1'b0, '0);       // R6 enabled irqs ignored
    step(1'b1, 1'b0, '0, '0, 1'b0, '0);       // R9 wait strobe in stop ignored
    step(1'b0, 1'b0, '0, '0, 1'b1, '0);       // R5 external wake from stop
    idle();
    // R7: each reset source on its own leaves stop
    for (int r = 0; r < NR; r++) begin
      step(1'b0, 1'b1, '0, '0, 1'b0, '0);
      step(1'b0, 1'b0, '0, '0, 1'b0, NR'(1) << r);
      idle();
    end
    // Random phase
    for (int k = 0; k < 4000; k++) begin
      logic          w, s, ex;
      logic [NI-1:0] rq, en;
      logic [NR-1:0] rs;
      w  = ($urandom % 8) == 0;
      s  = ($urandom % 10) == 0;
      rq = (($urandom % 4) == 0) ? NI'($urandom) : '0;
      en = NI'($urandom);
      ex = ($urandom % 15) == 0;
      rs = (($urandom % 50) == 0) ? NR'(1) << ($urandom % NR) : '0;
      step(w, s, rq, en, ex, rs);
    end
    finish_run();
  end
endmodule